// File: doc/BRIEF.md
# Protected Watchdog Timer with Restart Key

This block is a watchdog down-counter that advances only on pulses of a slow tick input, which stands for the dedicated low-speed oscillator. Software keeps it from expiring by writing a two-byte key to a refresh register: the byte 00h followed immediately by FFh. If the key is not written in time, the counter runs out, reloads itself, and raises either a reset request or an interrupt request for one cycle.

Configuration arrives on static inputs that model option storage held outside the block. One bit selects whether the counter starts by itself when reset is released or waits for a write to a start register. A two-bit field selects how long the timeout is. A protection bit turns on the slow oscillator and forces every underflow to become a reset request. The protection bit is sticky until the next system reset. Once the counter is running, nothing stops it, and a low-power indication input has no effect on it.

Top module: `wdt_guard`

## Requirements
- R1: While running, the counter loses one count at each clock edge where `slow_tick` is high. From a reload value V, underflow happens on the V+1-th tick.
- R2: `cfg_uf_sel` chooses the reload value. 00b selects 03FFh, 01b selects 0FFFh, 10b selects 1FFFh and 11b selects 3FFFh. The counter also reloads at system reset and at every underflow.
- R3: A write of 00h to address 0 arms the key. A write of FFh to address 0 reloads the counter only if it is the very next write after the arming write. Any other write in between, whatever its address or data, disarms the key and does not reload.
- R4: While the counter is stopped, key writes to address 0 have no effect. In particular, they do not start counting.
- R5: With `cfg_manual_start`=1, the counter stays stopped after reset until any write to address 1. With `cfg_manual_start`=0, it counts from the first edge after reset is released.
- R6: Once running, the counter never stops. Counting continues unchanged while `low_power` is high.
- R7: An underflow gives exactly one cycle of pulse, in the cycle after the underflowing tick edge. The pulse appears on `rst_req` when `cfg_act_reset`=1 or protection is active, and on `int_req` otherwise. The two outputs are never high together.
- R8: If `cfg_protect` is high at reset, or at any edge after it, protection becomes active and stays active until the next reset. While protection is active, `osc_en` is high and every underflow drives `rst_req`.
- R9: `osc_en` is high exactly when protection is active or the counter is running.
- R10: During and just after reset, `rst_req` and `int_req` are low, and the counter holds the selected reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_manual_start | input | 1 | 1: stay stopped after reset until start write; 0: start automatically |
| cfg_uf_sel | input | 2 | Reload value select |
| cfg_protect | input | 1 | Protection enable (sticky inside the block) |
| cfg_act_reset | input | 1 | Underflow action when unprotected: 1 reset request, 0 interrupt |
| slow_tick | input | 1 | One-cycle enable from the low-speed oscillator |
| low_power | input | 1 | Stop/wait-mode indication; ignored by the counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address: 0 refresh, 1 start |
| wr_data | input | DATA_W (8) | Register write data |
| rst_req | output | 1 | One-cycle reset request on underflow |
| int_req | output | 1 | One-cycle interrupt request on underflow |
| osc_en | output | 1 | Low-speed oscillator enable |

## Verification
The bench builds the block with its default parameters. Because the tick can be held high on every clock, all four reload selections run all the way to underflow within the run: 1024, 4096, 8192 and 16384 ticks. Random phases use sparse ticks and writes that lean toward the key bytes and the two register addresses. This makes arming, disarming by intervening writes, and refreshes that land on the underflow tick occur many times. These phases are checked cycle by cycle against a bench model.

// File: rtl/wdt_guard_pkg.sv
// Package: shared counter type and reload decode for the protected watchdog.
// Assumes the longest reload value (3FFFh) sets the counter width.
package wdt_guard_pkg;

    localparam int CNT_W = 14;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        UF_SEL_1K  = 2'b00,
        UF_SEL_4K  = 2'b01,
        UF_SEL_8K  = 2'b10,
        UF_SEL_16K = 2'b11
    } uf_sel_e;

    // Reload value as all-ones of a width chosen by the select field.
    function automatic cnt_t reload_of(input logic [1:0] sel);
        int unsigned bits;
        case (uf_sel_e'(sel))
            UF_SEL_1K: bits = 10;
            UF_SEL_4K: bits = 12;
            UF_SEL_8K: bits = 13;
            default:   bits = 14;
        endcase
        return cnt_t'((32'd1 << bits) - 32'd1);
    endfunction

endpackage

// File: rtl/wdt_key_detect.sv
// Module: detects the ordered two-write refresh key on one register address.
// Assumes that any write at all, to any address, between the two key bytes
// breaks the sequence. Key writes count only while enable is high.
module wdt_key_detect #(
    parameter int                 ADDR_W     = 4,
    parameter int                 DATA_W     = 8,
    parameter logic [ADDR_W-1:0]  KEY_ADDR   = '0,
    parameter logic [DATA_W-1:0]  KEY_FIRST  = '0,
    parameter logic [DATA_W-1:0]  KEY_SECOND = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              enable,
    output logic              refresh_o
);

    logic armed_q;
    logic key_hit;

    // A write to the key register that is allowed to act.
    assign key_hit   = wr_en && (wr_addr == KEY_ADDR) && enable;
    // The second key byte completes the sequence only from the armed state.
    assign refresh_o = key_hit && armed_q && (wr_data == KEY_SECOND);

    // Arming state: set by the first key byte, cleared by any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (key_hit) begin
            armed_q <= (wr_data == KEY_FIRST);
        end else if (wr_en) begin
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_mode_ctrl.sv
// Module: holds the run state and the sticky protection state.
// Assumes the configuration inputs are static copies of stored option bits.
// Nothing but reset can clear either state.
module wdt_mode_ctrl #(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] START_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_manual_start,
    input  logic              cfg_protect,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              running_o,
    output logic              protect_o
);

    logic running_q;
    logic protect_q;

    // Run state: chosen by start mode at reset, set by a start write, never cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= !cfg_manual_start;
        end else if (wr_en && (wr_addr == START_ADDR)) begin
            running_q <= 1'b1;
        end
    end

    // Protection state: captured at reset, then only ever set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            protect_q <= cfg_protect;
        end else if (cfg_protect) begin
            protect_q <= 1'b1;
        end
    end

    assign running_o = running_q;
    assign protect_o = protect_q;

endmodule

// File: rtl/wdt_down_counter.sv
// Module: reloadable down-counter with a registered underflow pulse.
// Assumes tick_en is already gated by the run state. On the same edge, a
// refresh takes priority over a tick and suppresses the underflow.
module wdt_down_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick_en,
    input  logic             refresh,
    output logic [CNT_W-1:0] cnt_o,
    output logic             underflow_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             uf_q;
    logic             at_zero;

    // The tick that arrives at zero is the underflowing tick.
    assign at_zero = (cnt_q == '0);

    // Count, reload and underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= reload_val;
            uf_q  <= 1'b0;
        end else begin
            uf_q <= tick_en && at_zero && !refresh;
            if (refresh) begin
                cnt_q <= reload_val;
            end else if (tick_en) begin
                cnt_q <= at_zero ? reload_val : cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o       = cnt_q;
    assign underflow_o = uf_q;

endmodule

// File: rtl/wdt_guard.sv
// Module: top of the protected watchdog. It joins the key detector, the mode
// control and the counter, and steers the underflow pulse to a reset or an
// interrupt request. Assumes slow_tick is a single-cycle enable that is
// synchronous to clk. low_power is accepted but deliberately does not stop
// the count.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int                ADDR_W       = 4,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] REFRESH_ADDR = 0,
    parameter logic [ADDR_W-1:0] START_ADDR   = 1,
    parameter logic [DATA_W-1:0] KEY_FIRST    = 8'h00,
    parameter logic [DATA_W-1:0] KEY_SECOND   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_manual_start,
    input  logic [1:0]        cfg_uf_sel,
    input  logic              cfg_protect,
    input  logic              cfg_act_reset,
    input  logic              slow_tick,
    input  logic              low_power,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_req,
    output logic              int_req,
    output logic              osc_en
);

    cnt_t reload_val;
    cnt_t cnt_q;
    logic running_q;
    logic protect_q;
    logic refresh;
    logic tick_en;
    logic underflow;
    logic act_is_reset;

    // Reload value decoded from the static select field.
    assign reload_val = reload_of(cfg_uf_sel);
    // Ticks count only once the counter runs.
    assign tick_en    = slow_tick && running_q;

    wdt_key_detect #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .KEY_ADDR  (REFRESH_ADDR),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .enable   (running_q),
        .refresh_o(refresh)
    );

    wdt_mode_ctrl #(
        .ADDR_W    (ADDR_W),
        .START_ADDR(START_ADDR)
    ) u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_manual_start(cfg_manual_start),
        .cfg_protect     (cfg_protect),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .running_o       (running_q),
        .protect_o       (protect_q)
    );

    wdt_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_val (reload_val),
        .tick_en    (tick_en),
        .refresh    (refresh),
        .cnt_o      (cnt_q),
        .underflow_o(underflow)
    );

    // Protection overrides the configured underflow action.
    assign act_is_reset = protect_q || cfg_act_reset;
    assign rst_req      = underflow && act_is_reset;
    assign int_req      = underflow && !act_is_reset;
    // The oscillator runs whenever it is needed or forced.
    assign osc_en       = protect_q || running_q;

endmodule

// File: rtl/wdt_guard_chk.sv
// Checker: temporal properties of the protected watchdog, bound into the top.
module wdt_guard_chk
    import wdt_guard_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic rst_req,
    input logic int_req,
    input logic osc_en,
    input logic running,
    input logic protect,
    input logic low_power,
    input logic slow_tick,
    input cnt_t cnt
);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && int_req)); // R7
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7
    AST_INT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> !int_req); // R7
    AST_UF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || int_req) |-> $past(slow_tick)); // R1
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (running && low_power) |=> running); // R6
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(cnt)); // R5
    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        protect |=> protect); // R8
    AST_PROT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> osc_en); // R8
    AST_PROT_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> !int_req); // R8

endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .int_req  (int_req),
    .osc_en   (osc_en),
    .running  (running_q),
    .protect  (protect_q),
    .low_power(low_power),
    .slow_tick(slow_tick),
    .cnt      (cnt_q)
);

// File: tb/wdt_guard_bench.sv
// Bench: directed timing runs plus random phases checked against a bench model.
module wdt_guard_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_manual_start = 1'b0;
    logic [1:0] cfg_uf_sel = 2'b00;
    logic       cfg_protect = 1'b0;
    logic       cfg_act_reset = 1'b1;
    logic       slow_tick = 1'b0;
    logic       low_power = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_req;
    logic       int_req;
    logic       osc_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_guard u_wdt_guard (
        .clk(clk), .rst_n(rst_n), .cfg_manual_start(cfg_manual_start),
        .cfg_uf_sel(cfg_uf_sel), .cfg_protect(cfg_protect),
        .cfg_act_reset(cfg_act_reset), .slow_tick(slow_tick),
        .low_power(low_power), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rst_req(rst_req), .int_req(int_req),
        .osc_en(osc_en)
    );

    function automatic int reload_f(input logic [1:0] sel);
        case (sel)
            2'b00:   return 32'h03FF;
            2'b01:   return 32'h0FFF;
            2'b10:   return 32'h1FFF;
            default: return 32'h3FFF;
        endcase
    endfunction

    // Bench model of the requirements, updated at each edge.
    int m_cnt = 0;
    bit m_run = 1'b0, m_arm = 1'b0, m_prot = 1'b0, m_uf = 1'b0;
    bit m_hit, m_rf, m_te;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = reload_f(cfg_uf_sel);
            m_run  = !cfg_manual_start;
            m_arm  = 1'b0;
            m_prot = cfg_protect;
            m_uf   = 1'b0;
        end else begin
            m_hit = wr_en && (wr_addr == 4'h0) && m_run;
            m_rf  = m_hit && m_arm && (wr_data == 8'hFF);
            m_te  = slow_tick && m_run;
            m_uf  = m_te && (m_cnt == 0) && !m_rf;
            if (m_rf) m_cnt = reload_f(cfg_uf_sel);
            else if (m_te) m_cnt = (m_cnt == 0) ? reload_f(cfg_uf_sel) : m_cnt - 1;
            if (wr_en) m_arm = m_hit && (wr_data == 8'h00);
            if (wr_en && wr_addr == 4'h1) m_run = 1'b1;
            if (cfg_protect) m_prot = 1'b1;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000 && !done) begin
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        bit er, ei, eo;
        er = m_uf && (m_prot || cfg_act_reset);
        ei = m_uf && !(m_prot || cfg_act_reset);
        eo = m_prot || m_run;
        check(rst_req == er, "R7 rst_req model", rst_req, er);
        check(int_req == ei, "R7 int_req model", int_req, ei);
        check(osc_en == eo, "R9 osc_en model", osc_en, eo);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic do_reset(input bit manual, input logic [1:0] sel, input bit prot, input bit act);
        cfg_manual_start = manual;
        cfg_uf_sel = sel;
        cfg_protect = prot;
        cfg_act_reset = act;
        wr_en = 1'b0;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    // Count edges until an underflow pulse, then check timing, route and width.
    task automatic measure(input string tag, input int exp_n, input bit exp_rst);
        int n = 0;
        while (!rst_req && !int_req && n < 20000) begin
            step();
            n++;
        end
        check(n == exp_n, tag, n, exp_n);
        check(rst_req == exp_rst, "R7 route", rst_req, exp_rst);
        step();
        check(!rst_req && !int_req, "R7 single pulse", rst_req | int_req, 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        slow_tick = 1'b1;

        // R10 reset state, R4 key ignored while stopped, R5 manual start.
        do_reset(1'b1, 2'b00, 1'b0, 1'b1);
        check(osc_en == 1'b0, "R10 osc_en after reset", osc_en, 0);
        check(rst_req == 1'b0 && int_req == 1'b0, "R10 requests low", rst_req | int_req, 0);
        wr(4'h0, 8'h00);
        wr(4'h0, 8'hFF);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 2000; i++) begin
                step();
                seen |= rst_req | int_req;
            end
            check(!seen, "R4 stopped stays silent", seen, 0);
        end
        check(osc_en == 1'b0, "R4 key did not start", osc_en, 0);
        wr(4'h1, 8'h5A);
        measure("R5 start write period", 1024, 1'b1);

        // R1/R6 automatic start with low-power indication held high.
        low_power = 1'b1;
        do_reset(1'b0, 2'b00, 1'b0, 1'b1);
        measure("R1 R6 period under low_power", 1024, 1'b1);
        low_power = 1'b0;

        // R3 valid key reloads.
        do_reset(1'b0, 2'b00, 1'b0, 1'b1);
        repeat (600) step();
        wr(4'h0, 8'h00);
        wr(4'h0, 8'hFF);
        measure("R3 refresh reload", 1024, 1'b1);

        // R3 broken keys: wrong value, then an unrelated write in between.
        do_reset(1'b0, 2'b00, 1'b0, 1'b1);
        repeat (100) step();
        wr(4'h0, 8'h00);
        wr(4'h0, 8'h55);
        wr(4'h0, 8'hFF);
        repeat (100) step();
        wr(4'h0, 8'h00);
        wr(4'h2, 8'h00);
        wr(4'h0, 8'hFF);
        measure("R3 broken key no reload", 1024 - 206, 1'b1);

        // R2 remaining reload selections.
        for (int s = 1; s < 4; s++) begin
            do_reset(1'b0, 2'(s), 1'b0, 1'b1);
            measure("R2 reload select", reload_f(2'(s)) + 1, 1'b1);
        end

        // R7 interrupt route when unprotected.
        do_reset(1'b0, 2'b00, 1'b0, 1'b0);
        measure("R7 interrupt route", 1024, 1'b0);

        // R8 protection: forced oscillator, sticky, forced reset action.
        do_reset(1'b1, 2'b00, 1'b1, 1'b0);
        check(osc_en == 1'b1, "R8 osc forced", osc_en, 1);
        cfg_protect = 1'b0;
        step();
        check(osc_en == 1'b1, "R8 protection sticky", osc_en, 1);
        wr(4'h1, 8'h00);
        measure("R8 forced reset action", 1024, 1'b1);
        do_reset(1'b1, 2'b00, 1'b0, 1'b0);
        check(osc_en == 1'b0, "R8 cleared by reset", osc_en, 0);

        // Random phases against the model (R1 R3 R6 R7 R8 R9).
        for (int seg = 0; seg < 3; seg++) begin
            do_reset(1'($urandom % 2), 2'b00, 1'b0, 1'($urandom % 2));
            for (int i = 0; i < 20000; i++) begin
                slow_tick = ($urandom % 2) == 0;
                low_power = ($urandom % 4) == 0;
                cfg_protect = ($urandom % 5000) == 0;
                wr_en = ($urandom % 8) == 0;
                wr_addr = 4'($urandom % 3);
                case ($urandom % 4)
                    0, 1:    wr_data = 8'h00;
                    2:       wr_data = 8'hFF;
                    default: wr_data = 8'($urandom);
                endcase
                if (($urandom % 3) != 0 && wr_addr == 4'h1 && m_run) wr_addr = 4'h0;
                step();
            end
            wr_en = 1'b0;
            cfg_protect = 1'b0;
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule